// File: doc/BRIEF.md
# I2C Target-Side Line-to-Request Bridge

This block sits on the target side of a two-wire serial bus. It samples the clock and data lines driven by a bus controller, detects start and stop conditions, and shifts bits in and out. It turns the bus activity into byte-level requests on a simple downstream port. A downstream agent answers each request: it accepts or rejects an address or data byte, or it supplies a byte to be read.

The block answers on the data line through an open-drain style drive value. It pulls the line low for an acknowledge and for read bits that are zero. It presents the wired-AND of that drive and the sampled controller level as the line level seen on the bus. The response changes on the clock rising edge and is released on every falling edge.

The downstream port is a valid/ready handshake. A request stays on the port until the agent raises ready for one cycle. In that cycle the agent also gives a reject flag or a read byte. While a request is outstanding, the bridge processes no bus events. The agent is expected to answer well within one bus phase.

Top module: `i2c_line_bridge`

## Requirements
- R1: After reset, the drive output and the bus level output are both 1, and no request is valid.
- R2: A falling data level while the clock is high is a start condition. From any state it restarts bit capture, and the next complete byte is treated as an address byte.
- R3: A rising data level while the clock is high is a stop condition. It raises an end request (op code 4) only if an address byte was sent downstream since the last start or end. Otherwise it raises no request. In both cases the block then goes idle.
- R4: Data level changes while the clock is low raise no request and do not disturb the byte being captured.
- R5: Write bits are captured MSB first, one on each clock rising edge. At the ninth rising edge, the first byte after a start raises a start request (op code 1) carrying the byte's upper seven bits as address and bit 0 as the read flag (1 = read).
- R6: Each later written byte raises a write request (op code 2) carrying the byte.
- R7: When the agent accepts an address or write byte, the drive output goes to 0 after the handshake and stays at 0 until the next clock falling edge.
- R8: When the agent rejects an address or write byte, the drive stays 1 and an end request (op code 4) follows. Further clock pulses raise no request. A later stop raises no request.
- R9: After an accepted read address, the next rising edge raises a fetch request (op code 3). The fetched byte is driven MSB first, one bit per rising edge, over eight rising edges.
- R10: At the rising edge after a read byte, a low data level starts the next fetch. A high level raises a nack request (op code 5), after which clocks are ignored, with no request and the drive at 1, until a start or stop. A later stop raises an end request.
- R11: Every clock falling edge sets the drive output to 1.
- R12: The bus level output equals the drive output ANDed with the sampled controller data level.
- R13: A valid request keeps its op code and payload unchanged until ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Clock line level from the controller |
| sda_i | input | 1 | Data line level from the controller |
| sda_drive_o | output | 1 | Open-drain drive value of the block (0 pulls low) |
| sda_bus_o | output | 1 | Resolved line level: drive AND sampled controller level |
| req_valid_o | output | 1 | Downstream request valid |
| req_op_o | output | 3 | Request code: 1 start, 2 write, 3 fetch, 4 end, 5 nack |
| req_addr_o | output | 7 | Target address for a start request |
| req_rnw_o | output | 1 | Read flag for a start request |
| req_wdata_o | output | 8 | Byte for a write request |
| req_ready_i | input | 1 | Agent accepts the request and presents its answer |
| rsp_nack_i | input | 1 | Agent rejects the address or write byte |
| rsp_rdata_i | input | 8 | Byte returned for a fetch request |

## Verification
A line change reaches the state machine on the third clock edge after it is driven, because it passes two synchronizer stages and the stored previous level. A request therefore becomes valid three edges after the causing line change. The drive output reflects an accepted answer one edge after ready. The agent model in the bench holds each request for zero to three extra cycles, so an answer can take up to about six cycles. Each bench bus phase lasts sixteen cycles, and every output is sampled at the end of its phase, after the latest possible answer and before the next line change.

// File: rtl/i2cbr_pkg.sv
package i2cbr_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_START = 3'd1,
        OP_WRITE = 3'd2,
        OP_READ  = 3'd3,
        OP_END   = 3'd4,
        OP_NACK  = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR,
        ST_ACKW,
        ST_RD,
        ST_CACK,
        ST_HALT,
        ST_BUSY
    } st_e;

endpackage

// File: rtl/i2cbr_line_watch.sv
module i2cbr_line_watch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic ev_start,
    output logic ev_stop,
    output logic ev_rise,
    output logic ev_fall
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_pipe;
        logic [SYNC_STAGES-1:0] sda_pipe;
        logic                   scl_last;
        logic                   sda_last;
    } lw_t;

    lw_t r_q, r_d;
    logic scl_now, sda_now, scl_chg, sda_chg;

    assign scl_now = r_q.scl_pipe[SYNC_STAGES-1];
    assign sda_now = r_q.sda_pipe[SYNC_STAGES-1];
    assign scl_chg = scl_now != r_q.scl_last;
    assign sda_chg = sda_now != r_q.sda_last;

    always_comb begin
        r_d          = r_q;
        r_d.scl_pipe = {r_q.scl_pipe[SYNC_STAGES-2:0], scl_i};
        r_d.sda_pipe = {r_q.sda_pipe[SYNC_STAGES-2:0], sda_i};
        r_d.scl_last = scl_now;
        r_d.sda_last = sda_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    // data edges are judged against the stored clock level
    assign ev_start = sda_chg && r_q.scl_last && !sda_now;
    assign ev_stop  = sda_chg && r_q.scl_last &&  sda_now;
    assign ev_rise  = scl_chg &&  scl_now;
    assign ev_fall  = scl_chg && !scl_now;
    assign scl_lvl  = r_q.scl_last;
    assign sda_lvl  = r_q.sda_last;

endmodule

// File: rtl/i2cbr_core.sv
module i2cbr_core
    import i2cbr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_rise,
    input  logic              ev_fall,
    input  logic              req_ready,
    input  logic              rsp_nack,
    input  logic [DATA_W-1:0] rsp_rdata,
    output logic              drive,
    output logic              req_valid,
    output logic [2:0]        req_op,
    output logic [DATA_W-2:0] req_addr,
    output logic              req_rnw,
    output logic [DATA_W-1:0] req_wdata
);
    localparam int ADDR_W = DATA_W - 1;
    localparam int CNT_W  = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        st_e               st;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
        logic              addr_seen;
        logic              rnw;
        logic              drive;
        logic              vld;
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } core_t;

    core_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (r_q.st == ST_BUSY) begin
            if (req_ready) begin
                r_d.vld = 1'b0;
                case (r_q.op)
                    OP_START, OP_WRITE: begin
                        if (rsp_nack) begin
                            r_d.drive     = 1'b1;
                            r_d.addr_seen = 1'b0;
                            r_d.vld       = 1'b1;
                            r_d.op        = OP_END;
                        end else begin
                            r_d.drive = 1'b0;
                            r_d.cnt   = '0;
                            r_d.st    = r_q.rnw ? ST_RD : ST_WR;
                        end
                    end
                    OP_READ: begin
                        r_d.drive = rsp_rdata[DATA_W-1];
                        r_d.sh    = {rsp_rdata[DATA_W-2:0], 1'b0};
                        r_d.cnt   = CNT_W'(1);
                        r_d.st    = ST_RD;
                    end
                    OP_NACK: r_d.st = ST_HALT;
                    default: r_d.st = ST_IDLE;
                endcase
            end
        end else if (ev_start) begin
            r_d.st        = ST_WR;
            r_d.cnt       = '0;
            r_d.addr_seen = 1'b0;
            r_d.drive     = 1'b1;
        end else if (ev_stop) begin
            r_d.drive = 1'b1;
            if (r_q.addr_seen) begin
                r_d.addr_seen = 1'b0;
                r_d.vld       = 1'b1;
                r_d.op        = OP_END;
                r_d.st        = ST_BUSY;
            end else begin
                r_d.st = ST_IDLE;
            end
        end else if (ev_fall) begin
            r_d.drive = 1'b1;
        end else if (ev_rise) begin
            case (r_q.st)
                ST_WR: begin
                    r_d.drive = 1'b1;
                    r_d.sh    = {r_q.sh[DATA_W-2:0], sda_lvl};
                    if (r_q.cnt == LAST_BIT) begin
                        r_d.cnt = '0;
                        r_d.st  = ST_ACKW;
                    end else begin
                        r_d.cnt = r_q.cnt + CNT_W'(1);
                    end
                end
                ST_ACKW: begin
                    r_d.vld = 1'b1;
                    r_d.st  = ST_BUSY;
                    if (!r_q.addr_seen) begin
                        r_d.addr      = r_q.sh[DATA_W-1:1];
                        r_d.rnw       = r_q.sh[0];
                        r_d.addr_seen = 1'b1;
                        r_d.op        = OP_START;
                    end else begin
                        r_d.wdata = r_q.sh;
                        r_d.op    = OP_WRITE;
                    end
                end
                ST_RD: begin
                    if (r_q.cnt == '0) begin
                        r_d.vld = 1'b1;
                        r_d.op  = OP_READ;
                        r_d.st  = ST_BUSY;
                    end else begin
                        r_d.drive = r_q.sh[DATA_W-1];
                        r_d.sh    = {r_q.sh[DATA_W-2:0], 1'b0};
                        if (r_q.cnt == LAST_BIT) begin
                            r_d.cnt = '0;
                            r_d.st  = ST_CACK;
                        end else begin
                            r_d.cnt = r_q.cnt + CNT_W'(1);
                        end
                    end
                end
                ST_CACK: begin
                    r_d.drive = 1'b1;
                    if (sda_lvl) begin
                        r_d.vld = 1'b1;
                        r_d.op  = OP_NACK;
                        r_d.st  = ST_BUSY;
                    end else begin
                        r_d.cnt = '0;
                        r_d.st  = ST_RD;
                    end
                end
                default: r_d.drive = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.op    <= OP_NONE;
            r_q.drive <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign drive     = r_q.drive;
    assign req_valid = r_q.vld;
    assign req_op    = r_q.op;
    assign req_addr  = r_q.addr;
    assign req_rnw   = r_q.rnw;
    assign req_wdata = r_q.wdata;

    // R13: request held until accepted
    p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.vld && !req_ready) |=> (r_q.vld && $stable(r_q.op) && $stable(r_q.addr)
                                     && $stable(r_q.wdata) && $stable(r_q.rnw)));

    // R2: start restarts capture with the address phase
    p_start_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start && r_q.st != ST_BUSY) |=> (r_q.st == ST_WR && !r_q.addr_seen));

    // R11: falling clock releases the drive
    p_fall_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_fall && r_q.st != ST_BUSY) |=> r_q.drive);

    // R4: with the clock low and no rising edge, nothing moves
    p_low_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_BUSY && !scl_lvl && !ev_rise) |=> ($stable(r_q.st) && !r_q.vld));

    // R7: an accepted byte is acknowledged by pulling low
    p_ack_pull_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.vld && req_ready && !rsp_nack && (r_q.op == OP_START || r_q.op == OP_WRITE))
        |=> !r_q.drive);

    // R8 / R10: the halted state raises nothing on clocks
    p_halt_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HALT && !ev_start && !ev_stop) |=> (!r_q.vld && r_q.drive));

endmodule

// File: rtl/i2c_line_bridge.sv
module i2c_line_bridge #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_drive_o,
    output logic              sda_bus_o,
    output logic              req_valid_o,
    output logic [2:0]        req_op_o,
    output logic [DATA_W-2:0] req_addr_o,
    output logic              req_rnw_o,
    output logic [DATA_W-1:0] req_wdata_o,
    input  logic              req_ready_i,
    input  logic              rsp_nack_i,
    input  logic [DATA_W-1:0] rsp_rdata_i
);
    logic scl_lvl, sda_lvl, ev_start, ev_stop, ev_rise, ev_fall;

    i2cbr_line_watch #(.SYNC_STAGES(SYNC_STAGES)) u_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .ev_start (ev_start),
        .ev_stop  (ev_stop),
        .ev_rise  (ev_rise),
        .ev_fall  (ev_fall)
    );

    i2cbr_core #(.DATA_W(DATA_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .ev_start  (ev_start),
        .ev_stop   (ev_stop),
        .ev_rise   (ev_rise),
        .ev_fall   (ev_fall),
        .req_ready (req_ready_i),
        .rsp_nack  (rsp_nack_i),
        .rsp_rdata (rsp_rdata_i),
        .drive     (sda_drive_o),
        .req_valid (req_valid_o),
        .req_op    (req_op_o),
        .req_addr  (req_addr_o),
        .req_rnw   (req_rnw_o),
        .req_wdata (req_wdata_o)
    );

    assign sda_bus_o = sda_drive_o & sda_lvl;

    // R1: quiet and released out of reset
    p_reset_released_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (sda_drive_o && !req_valid_o));

endmodule

// File: tb/i2c_line_bridge_bench.sv
module i2c_line_bridge_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda = 1'b1;
    logic req_ready = 1'b0, rsp_nack = 1'b0;
    logic [7:0] rsp_rdata = 8'h00;
    logic sda_drive_o, sda_bus_o, req_valid_o, req_rnw_o;
    logic [2:0] req_op_o;
    logic [6:0] req_addr_o;
    logic [7:0] req_wdata_o;

    always #10 clk = ~clk;

    i2c_line_bridge u_i2c_line_bridge (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .sda_drive_o(sda_drive_o), .sda_bus_o(sda_bus_o),
        .req_valid_o(req_valid_o), .req_op_o(req_op_o), .req_addr_o(req_addr_o),
        .req_rnw_o(req_rnw_o), .req_wdata_o(req_wdata_o),
        .req_ready_i(req_ready), .rsp_nack_i(rsp_nack), .rsp_rdata_i(rsp_rdata)
    );

    int tests = 0, fails = 0;
    int lg_n = 0;
    int lg_op[64], lg_addr[64], lg_rnw[64], lg_data[64];
    int rej_addr = 999, rej_data = 999;
    int hold_dly = 0;
    int rd_seed = 7;
    bit hold_bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // downstream agent model
    initial begin
        forever begin
            @(negedge clk);
            req_ready = 1'b0;
            rsp_nack  = 1'b0;
            if (rst_n && req_valid_o) begin
                int lop;
                lop = int'(req_op_o);
                for (int d = 0; d < hold_dly; d++) begin
                    @(negedge clk);
                    if (!req_valid_o || int'(req_op_o) != lop) hold_bad = 1;
                end
                if (lg_n < 64) begin
                    lg_op[lg_n]   = lop;
                    lg_addr[lg_n] = int'(req_addr_o);
                    lg_rnw[lg_n]  = int'(req_rnw_o);
                    lg_data[lg_n] = int'(req_wdata_o);
                end
                if (lop == 1) rsp_nack = (int'(req_addr_o) == rej_addr);
                if (lop == 2) rsp_nack = (int'(req_wdata_o) == rej_data);
                if (lop == 3) begin
                    rsp_rdata = 8'(rd_seed);
                    rd_seed   = (rd_seed * 37 + 11) % 256;
                    if (lg_n < 64) lg_data[lg_n] = int'(rsp_rdata);
                end
                lg_n++;
                req_ready = 1'b1;
                hold_dly  = (hold_dly + 1) % 4;
            end
        end
    end

    task automatic step();
        repeat (16) @(negedge clk);
    endtask
    task automatic put_scl(input logic v); scl = v; step(); endtask
    task automatic put_sda(input logic v); sda = v; step(); endtask

    task automatic bus_start();
        put_sda(1); put_scl(1); put_sda(0); put_scl(0);
    endtask
    task automatic bus_stop();
        put_sda(0); put_scl(1); put_sda(1);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            if (glitch) begin
                put_sda(!b[i]); put_sda(b[i]); put_sda(!b[i]);
            end
            put_sda(b[i]); put_scl(1); put_scl(0);
        end
        put_sda(1); put_scl(1);
        acked = (sda_drive_o == 1'b0);
        chk(sda_bus_o == sda_drive_o, "R12 bus level during ack", int'(sda_bus_o), int'(sda_drive_o));
        put_scl(0);
        chk(sda_drive_o == 1'b1, "R11 release after ack fall", int'(sda_drive_o), 1);
    endtask

    task automatic recv_byte(input logic ackbit, output logic [7:0] v);
        v = 8'h00;
        put_sda(1);
        for (int i = 0; i < 8; i++) begin
            put_scl(1);
            v = {v[6:0], sda_bus_o};
            put_scl(0);
            if (i == 7) chk(sda_drive_o == 1'b1, "R11 release after read bit", int'(sda_drive_o), 1);
        end
        put_sda(ackbit); put_scl(1); put_scl(0); put_sda(1);
    endtask

    initial begin
        bit ak;
        logic [7:0] v0, v1, v2;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(sda_drive_o == 1'b1, "R1 drive at reset", int'(sda_drive_o), 1);
        chk(sda_bus_o == 1'b1, "R1 bus at reset", int'(sda_bus_o), 1);
        chk(req_valid_o == 1'b0, "R1 no request at reset", int'(req_valid_o), 0);

        // write sweep: R5 R6 R7 R3
        for (int a = 0; a < 128; a += 11) begin
            int d1, d2;
            d1 = (a * 3 + 1) % 256;
            d2 = (a ^ 8'h5A) % 256;
            lg_n = 0;
            bus_start();
            send_byte({7'(a), 1'b0}, 0, ak);
            chk(ak, "R7 address acknowledged", int'(ak), 1);
            send_byte(8'(d1), 0, ak);
            chk(ak, "R7 data acknowledged", int'(ak), 1);
            send_byte(8'(d2), 0, ak);
            bus_stop();
            chk(lg_n == 4, "R3 request count write", lg_n, 4);
            chk(lg_op[0] == 1 && lg_addr[0] == a && lg_rnw[0] == 0, "R5 start request", lg_addr[0], a);
            chk(lg_op[1] == 2 && lg_data[1] == d1, "R6 first write byte", lg_data[1], d1);
            chk(lg_op[2] == 2 && lg_data[2] == d2, "R6 second write byte", lg_data[2], d2);
            chk(lg_op[3] == 4, "R3 end on stop", lg_op[3], 4);
        end

        // read sweep: R9 R10
        for (int a = 3; a < 128; a += 17) begin
            lg_n = 0;
            bus_start();
            send_byte({7'(a), 1'b1}, 0, ak);
            chk(ak, "R7 read address acknowledged", int'(ak), 1);
            recv_byte(1'b0, v0);
            recv_byte(1'b1, v1);
            chk(lg_op[0] == 1 && lg_rnw[0] == 1 && lg_addr[0] == a, "R5 read start", lg_rnw[0], 1);
            chk(lg_op[1] == 3 && int'(v0) == lg_data[1], "R9 first read byte", int'(v0), lg_data[1]);
            chk(lg_op[2] == 3 && int'(v1) == lg_data[2], "R10 low ack fetches next", int'(v1), lg_data[2]);
            chk(lg_n == 4 && lg_op[3] == 5, "R10 nack request", lg_op[3], 5);
            recv_byte(1'b0, v2);
            chk(v2 == 8'hFF, "R10 clocks ignored after nack", int'(v2), 255);
            chk(lg_n == 4, "R10 no request after nack", lg_n, 4);
            bus_stop();
            chk(lg_n == 5 && lg_op[4] == 4, "R10 stop after nack ends", lg_op[4], 4);
        end

        // R3: stop with no address phase
        lg_n = 0;
        bus_start();
        put_sda(1); put_scl(1); put_scl(0);
        put_sda(0); put_scl(1); put_scl(0);
        bus_stop();
        chk(lg_n == 0, "R3 no end without address", lg_n, 0);
        chk(sda_drive_o == 1'b1, "R3 released when idle", int'(sda_drive_o), 1);

        // R4: glitches while clock low
        lg_n = 0;
        bus_start();
        send_byte(8'hA6, 1, ak);
        chk(lg_n == 1 && lg_op[0] == 1 && lg_addr[0] == 8'h53 && lg_rnw[0] == 0,
            "R4 address intact through glitches", lg_addr[0], 8'h53);
        bus_stop();
        chk(lg_n == 2, "R4 only expected requests", lg_n, 2);

        // R8: address rejected
        lg_n = 0;
        rej_addr = 8'h2C;
        bus_start();
        send_byte({7'h2C, 1'b0}, 0, ak);
        chk(!ak, "R8 rejected address not acknowledged", int'(ak), 0);
        chk(lg_n == 2 && lg_op[1] == 4, "R8 end after reject", lg_op[1], 4);
        send_byte(8'h77, 0, ak);
        chk(!ak && lg_n == 2, "R8 clocks ignored after reject", lg_n, 2);
        bus_stop();
        chk(lg_n == 2, "R8 stop raises nothing", lg_n, 2);
        rej_addr = 999;

        // R8: data rejected
        lg_n = 0;
        rej_data = 8'hEE;
        bus_start();
        send_byte({7'h11, 1'b0}, 0, ak);
        send_byte(8'hEE, 0, ak);
        chk(!ak, "R8 rejected data not acknowledged", int'(ak), 0);
        chk(lg_n == 3 && lg_op[2] == 4, "R8 end after data reject", lg_op[2], 4);
        bus_stop();
        chk(lg_n == 3, "R8 stop after data reject", lg_n, 3);
        rej_data = 999;

        // R2: repeated start in mid byte
        lg_n = 0;
        bus_start();
        send_byte({7'h40, 1'b0}, 0, ak);
        put_sda(1); put_scl(1); put_scl(0);
        put_sda(0); put_scl(1); put_scl(0);
        bus_start();
        send_byte({7'h23, 1'b1}, 0, ak);
        chk(lg_n == 2 && lg_op[1] == 1 && lg_addr[1] == 8'h23 && lg_rnw[1] == 1,
            "R2 repeated start takes new address", lg_addr[1], 8'h23);
        recv_byte(1'b1, v0);
        chk(int'(v0) == lg_data[2], "R9 read after repeated start", int'(v0), lg_data[2]);
        bus_stop();
        chk(lg_n == 5 && lg_op[3] == 5 && lg_op[4] == 4, "R2 sequence end", lg_n, 5);

        chk(!hold_bad, "R13 request held until ready", int'(hold_bad), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule